// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This core keeps wall-clock time as packed BCD bytes: seconds, minutes, hours, day of month, month and a two-digit year. A weekday counter sits beside them. The count advances by one second on each single-cycle pulse of a one-hertz tick input, which is synchronous to the system clock. Day rollover follows the length of each month and inserts February 29 in leap years.

Software reaches the core through a flat byte-wide register bus. The bus carries the time fields, a full-date alarm, a control byte, a sticky status byte, an interrupt-enable byte and two general storage bytes for compensation. A run bit starts and stops counting. A snapshot bit copies the live time into shadow latches, so that a read of several bytes returns one consistent instant. The interrupt output is driven by the alarm match or by one selectable periodic event: every second, minute, hour or day.

The byte offsets are part of the interface. Time fields sit at 0x00 (seconds) up to 0x05 (year), with the weekday at 0x06. Alarm fields use the same order at 0x07 to 0x0C. Control is at 0x0D, status at 0x0E, interrupt enable at 0x0F, and the compensation bytes are at 0x10 and 0x11.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00 and weekday 0x00. Control reads 0x00, status reads 0x80 (power-up flag in bit 7), interrupt enable reads 0x00 and irq_o is low.
- R2: Counting depends on control bit 0. When it is 1, each tick advances the time by one second. When it is 0, ticks are ignored. Status bit 1 reads back the state of control bit 0.
- R3: Seconds and minutes wrap from 0x59 to 0x00, and hours wrap from 0x23 to 0x00. Each wrap carries into the next field.
- R4: The day wraps to 0x01 after the last day of the month. That is 0x30 for months 04, 06, 09 and 11, and 0x31 for the other months except February. February ends on 0x29 when the BCD year is divisible by 4 and on 0x28 otherwise. Month wraps from 0x12 to 0x01, year wraps from 0x99 to 0x00, and the weekday counts 0 to 6 on each day rollover.
- R5: A write to a time field at 0x00 to 0x06 takes effect at the next clock edge and changes no other field. If a counted tick falls in the same cycle, the written field takes the written value and the other fields advance as usual.
- R6: Writing control with bit 6 set copies the six live time fields into shadow latches. While bit 6 stays 1, reads of 0x00 to 0x05 return that copy. After bit 6 is cleared, those reads return the live counters again.
- R7: On a counted tick, status bit 2 is set. Bits 3, 4 and 5 are set when the seconds, minutes and hours wrap respectively. These bits are sticky.
- R8: Status bit 6 is set when all six time fields equal the six alarm fields after a counted tick.
- R9: Writing 1 to a status bit in positions 2 to 7 clears that bit, and writing 0 leaves it unchanged. If a bit is cleared in the same cycle that an event sets it, the bit stays set.
- R10: irq_o is high when enable bit 3 is set and status bit 6 is set. It is also high when enable bit 2 is set and the periodic flag selected by enable bits [1:0] is set. The selection codes are 00 for status bit 2, 01 for bit 3, 10 for bit 4 and 11 for bit 5.
- R11: The alarm fields, the two compensation bytes and enable bits [3:0] read back as written, with enable bits [7:4] reading 0. Addresses above 0x11 read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | ADDR_W (5) | Register byte address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Alarm or periodic interrupt, level |

## Verification
Two functions can collide in one cycle: a counted tick and a bus write. A tick arriving with a write to a time field must leave the written value in that field while the carries still move the other fields. A tick arriving with a write-one-to-clear of the flag it sets must leave the flag set. The bench provokes both by raising the tick and the write strobe before the same clock edge. It then reads every affected byte back through the bus and compares it with values worked out by hand from the requirements.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NF     = 6;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_SNAP = 6;

    localparam logic [7:0] A_WEEK = 8'h06;
    localparam logic [7:0] A_ALM0 = 8'h07;
    localparam logic [7:0] A_CTRL = 8'h0D;
    localparam logic [7:0] A_STAT = 8'h0E;
    localparam logic [7:0] A_IEN  = 8'h0F;
    localparam logic [7:0] A_CMP0 = 8'h10;
    localparam int         NCMP   = 2;

    typedef logic [NF-1:0][7:0] bcd_time_t;

    typedef struct packed {
        bcd_time_t  tm;
        logic [7:0] week;
    } cal_t;

    localparam bcd_time_t TIME_RST = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v == last)        return first;
        if (v[3:0] == 4'h9)   return {v[7:4] + 4'h1, 4'h0};
        return {v[7:4], v[3:0] + 4'h1};
    endfunction

    function automatic logic leap_year(input logic [7:0] y);
        if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
        return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            advance_i,
    input  logic [NF:0]     wr_mask_i,
    input  logic [7:0]      wr_val_i,
    output bcd_time_t       cur_o,
    output bcd_time_t       nxt_o,
    output logic [7:0]      week_o,
    output logic [3:0]      evt_o
);

    cal_t cal_d, cal_q;

    always_comb begin
        cal_d = cal_q;
        evt_o = '0;
        if (advance_i) begin
            evt_o[0] = 1'b1;
            cal_d.tm[F_SEC] = bcd_step(cal_q.tm[F_SEC], 8'h59, 8'h00);
            if (cal_q.tm[F_SEC] == 8'h59) begin
                evt_o[1] = 1'b1;
                cal_d.tm[F_MIN] = bcd_step(cal_q.tm[F_MIN], 8'h59, 8'h00);
                if (cal_q.tm[F_MIN] == 8'h59) begin
                    evt_o[2] = 1'b1;
                    cal_d.tm[F_HOUR] = bcd_step(cal_q.tm[F_HOUR], 8'h23, 8'h00);
                    if (cal_q.tm[F_HOUR] == 8'h23) begin
                        evt_o[3] = 1'b1;
                        cal_d.week = (cal_q.week >= 8'd6) ? 8'd0 : cal_q.week + 8'd1;
                        cal_d.tm[F_DAY] = bcd_step(cal_q.tm[F_DAY],
                            month_last(cal_q.tm[F_MON], cal_q.tm[F_YEAR]), 8'h01);
                        if (cal_q.tm[F_DAY] == month_last(cal_q.tm[F_MON], cal_q.tm[F_YEAR])) begin
                            cal_d.tm[F_MON] = bcd_step(cal_q.tm[F_MON], 8'h12, 8'h01);
                            if (cal_q.tm[F_MON] == 8'h12)
                                cal_d.tm[F_YEAR] = bcd_step(cal_q.tm[F_YEAR], 8'h99, 8'h00);
                        end
                    end
                end
            end
        end
        for (int k = 0; k < NF; k++) begin
            if (wr_mask_i[k]) cal_d.tm[k] = wr_val_i;
        end
        if (wr_mask_i[NF]) cal_d.week = wr_val_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cal_q.tm   <= TIME_RST;
            cal_q.week <= 8'h00;
        end else begin
            cal_q <= cal_d;
        end
    end

    assign cur_o  = cal_q.tm;
    assign nxt_o  = cal_d.tm;
    assign week_o = cal_q.week;

    // R2: without a counted tick or a write the calendar holds
    p_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!advance_i && wr_mask_i == '0) |=> ($stable(cal_q.tm) && $stable(cal_q.week)));

    // R2: a counted tick with no write always moves the seconds
    p_tick_moves_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (advance_i && wr_mask_i == '0) |=> (cal_q.tm[F_SEC] != $past(cal_q.tm[F_SEC])));

    // R5: a written field holds the written byte after the edge
    p_write_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_mask_i[F_MIN] |=> (cal_q.tm[F_MIN] == $past(wr_val_i)));

endmodule

// File: rtl/rtc_flags.sv
module rtc_flags
    import rtc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        run_i,
    input  logic [3:0]  evt_i,
    input  logic        alarm_hit_i,
    input  logic        clr_i,
    input  logic [5:0]  clr_bits_i,
    input  logic [3:0]  ien_i,
    output logic [7:0]  status_o,
    output logic        irq_o
);

    localparam int FL_ALM = 4;
    localparam int FL_PWR = 5;

    typedef struct packed {
        logic [5:0] flg;
    } flags_t;

    flags_t fl_d, fl_q;
    logic   sel_flag;

    always_comb begin
        fl_d = fl_q;
        if (clr_i) fl_d.flg = fl_q.flg & ~clr_bits_i;
        fl_d.flg[3:0]   = fl_d.flg[3:0] | evt_i;
        fl_d.flg[FL_ALM] = fl_d.flg[FL_ALM] | alarm_hit_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fl_q.flg <= 6'b100000;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign sel_flag = fl_q.flg[ien_i[1:0]];
    assign irq_o    = (ien_i[3] & fl_q.flg[FL_ALM]) | (ien_i[2] & sel_flag);
    assign status_o = {fl_q.flg, run_i, 1'b0};

    // R9: the alarm flag survives any cycle that does not clear it
    p_alarm_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fl_q.flg[FL_ALM] && !(clr_i && clr_bits_i[FL_ALM])) |=> fl_q.flg[FL_ALM]);

    // R9: a match always leaves the flag set, even against a clear
    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alarm_hit_i |=> fl_q.flg[FL_ALM]);

    // R10: both enables off keeps the line low
    p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ien_i[3:2] == 2'b00) |-> !irq_o);

    // R1: the power-up flag can only go from 1 to 0 through a clear
    p_pwr_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fl_q.flg[FL_PWR] && !(clr_i && clr_bits_i[FL_PWR])) |=> fl_q.flg[FL_PWR]);

endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sec_tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] AD_WEEK = ADDR_W'(A_WEEK);
    localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
    localparam logic [ADDR_W-1:0] AD_LAST = ADDR_W'(A_CMP0 + NCMP - 1);

    typedef struct packed {
        logic                  run;
        logic                  snap;
        logic [3:0]            ien;
        bcd_time_t             alarm;
        logic [NCMP-1:0][7:0]  comp;
        bcd_time_t             shadow;
    } regs_t;

    regs_t       regs_d, regs_q;
    logic [NF:0] cal_wmask;
    logic        ctrl_wr;
    logic        stat_wr;
    logic        advance;
    logic        alarm_hit;
    bcd_time_t   cal_cur;
    bcd_time_t   cal_nxt;
    logic [7:0]  cal_week;
    logic [3:0]  cal_evt;
    logic [7:0]  status;

    for (genvar g = 0; g < NF; g++) begin : g_time_wdec
        assign cal_wmask[g] = wr_en_i && (addr_i == ADDR_W'(g));
    end
    assign cal_wmask[NF] = wr_en_i && (addr_i == AD_WEEK);

    assign ctrl_wr   = wr_en_i && (addr_i == AD_CTRL);
    assign stat_wr   = wr_en_i && (addr_i == AD_STAT);
    assign advance   = sec_tick_i && regs_q.run;
    assign alarm_hit = advance && (cal_nxt == regs_q.alarm);

    always_comb begin
        regs_d = regs_q;
        if (ctrl_wr) begin
            regs_d.run  = wdata_i[CTRL_RUN];
            regs_d.snap = wdata_i[CTRL_SNAP];
            if (wdata_i[CTRL_SNAP]) regs_d.shadow = cal_cur;
        end
        if (wr_en_i && addr_i == AD_IEN) regs_d.ien = wdata_i[3:0];
        for (int k = 0; k < NF; k++) begin
            if (wr_en_i && addr_i == ADDR_W'(A_ALM0 + k)) regs_d.alarm[k] = wdata_i;
        end
        for (int k = 0; k < NCMP; k++) begin
            if (wr_en_i && addr_i == ADDR_W'(A_CMP0 + k)) regs_d.comp[k] = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    rtc_calendar u_cal (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .advance_i (advance),
        .wr_mask_i (cal_wmask),
        .wr_val_i  (wdata_i),
        .cur_o     (cal_cur),
        .nxt_o     (cal_nxt),
        .week_o    (cal_week),
        .evt_o     (cal_evt)
    );

    rtc_flags u_flags (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .run_i       (regs_q.run),
        .evt_i       (cal_evt),
        .alarm_hit_i (alarm_hit),
        .clr_i       (stat_wr),
        .clr_bits_i  (wdata_i[7:2]),
        .ien_i       (regs_q.ien),
        .status_o    (status),
        .irq_o       (irq_o)
    );

    always_comb begin
        rdata_o = 8'h00;
        for (int k = 0; k < NF; k++) begin
            if (addr_i == ADDR_W'(k)) rdata_o = regs_q.snap ? regs_q.shadow[k] : cal_cur[k];
            if (addr_i == ADDR_W'(A_ALM0 + k)) rdata_o = regs_q.alarm[k];
        end
        for (int k = 0; k < NCMP; k++) begin
            if (addr_i == ADDR_W'(A_CMP0 + k)) rdata_o = regs_q.comp[k];
        end
        if (addr_i == AD_WEEK) rdata_o = cal_week;
        if (addr_i == AD_CTRL) rdata_o = {1'b0, regs_q.snap, 5'b0, regs_q.run};
        if (addr_i == AD_STAT) rdata_o = status;
        if (addr_i == AD_IEN)  rdata_o = {4'b0, regs_q.ien};
    end

    // R11: addresses past the map read as zero
    p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i > AD_LAST) |-> (rdata_o == 8'h00));

    // R6: the shadow copy is frozen while snapshot mode is held
    p_shadow_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.snap && !ctrl_wr) |=> $stable(regs_q.shadow));

    // R2: a tick while stopped leaves the seconds alone
    p_stopped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!regs_q.run && !cal_wmask[F_SEC]) |=> $stable(cal_cur[F_SEC]));

endmodule

// File: tb/rtc_bcd_core_tb.sv
module rtc_bcd_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_bcd_core #(.ADDR_W(5)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .sec_tick_i (tick),
        .addr_i     (addr),
        .wr_en_i    (wr_en),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_o      (irq)
    );

    // {write, addr, data, expected read}
    localparam int NV = 18;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h07, 8'h11, 8'h00}, {1'b0, 8'h07, 8'h00, 8'h11},
        {1'b1, 8'h0C, 8'h42, 8'h00}, {1'b0, 8'h0C, 8'h00, 8'h42},
        {1'b1, 8'h10, 8'hA5, 8'h00}, {1'b0, 8'h10, 8'h00, 8'hA5},
        {1'b1, 8'h11, 8'h3C, 8'h00}, {1'b0, 8'h11, 8'h00, 8'h3C},
        {1'b1, 8'h0F, 8'hFB, 8'h00}, {1'b0, 8'h0F, 8'h00, 8'h0B},
        {1'b1, 8'h0F, 8'h00, 8'h00}, {1'b0, 8'h0F, 8'h00, 8'h00},
        {1'b1, 8'h06, 8'h04, 8'h00}, {1'b0, 8'h06, 8'h00, 8'h04},
        {1'b1, 8'h12, 8'h77, 8'h00}, {1'b0, 8'h12, 8'h00, 8'h00},
        {1'b0, 8'h1F, 8'h00, 8'h00}, {1'b0, 8'h08, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a[4:0]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a[4:0];
        #1 chk(req, rdata, exp);
    endtask

    task automatic irq_is(input string req, input logic exp);
        #1 chk(req, {7'b0, irq}, {7'b0, exp});
    endtask

    task automatic tick1();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic tick_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        tick = 1'b1; addr = a[4:0]; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
        wr(8'h05, y); wr(8'h04, mo); wr(8'h03, d);
        wr(8'h02, h); wr(8'h01, mi); wr(8'h00, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd("R1 sec", 8'h00, 8'h00);
        rd("R1 day", 8'h03, 8'h01);
        rd("R1 month", 8'h04, 8'h01);
        rd("R1 year", 8'h05, 8'h00);
        rd("R1 week", 8'h06, 8'h00);
        rd("R1 ctrl", 8'h0D, 8'h00);
        rd("R1 status", 8'h0E, 8'h80);
        irq_is("R1 irq", 1'b0);

        // R11 register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
            else rd("R11 table", VEC[i][23:16], VEC[i][7:0]);
        end

        // R2 stopped, then running
        tick1();
        rd("R2 stopped", 8'h00, 8'h00);
        wr(8'h0D, 8'h01);
        rd("R2 run status", 8'h0E, 8'h82);
        tick1(); tick1(); tick1();
        rd("R2 three ticks", 8'h00, 8'h03);
        rd("R7 sec flag", 8'h0E, 8'h86);
        wr(8'h0E, 8'h00);
        rd("R9 zero write", 8'h0E, 8'h86);
        wr(8'h0E, 8'hFC);
        rd("R9 clear all", 8'h0E, 8'h02);

        // R3 R4 R7 full rollover
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        wr(8'h06, 8'h06);
        tick1();
        rd("R3 sec", 8'h00, 8'h00);
        rd("R3 min", 8'h01, 8'h00);
        rd("R3 hour", 8'h02, 8'h00);
        rd("R4 day", 8'h03, 8'h01);
        rd("R4 month", 8'h04, 8'h01);
        rd("R4 year", 8'h05, 8'h00);
        rd("R4 week", 8'h06, 8'h00);
        rd("R7 all events", 8'h0E, 8'h3E);

        // R4 month lengths
        set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); tick1();
        rd("R4 leap feb day", 8'h03, 8'h29);
        rd("R4 leap feb month", 8'h04, 8'h02);
        set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59); tick1();
        rd("R4 leap end day", 8'h03, 8'h01);
        rd("R4 leap end month", 8'h04, 8'h03);
        set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59); tick1();
        rd("R4 plain feb day", 8'h03, 8'h01);
        rd("R4 plain feb month", 8'h04, 8'h03);
        set_time(8'h23, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59); tick1();
        rd("R4 april day", 8'h03, 8'h01);
        rd("R4 april month", 8'h04, 8'h05);
        set_time(8'h23, 8'h01, 8'h30, 8'h23, 8'h59, 8'h59); tick1();
        rd("R4 jan day", 8'h03, 8'h31);
        rd("R4 jan month", 8'h04, 8'h01);

        // R5 write and tick collisions
        set_time(8'h23, 8'h01, 8'h01, 8'h00, 8'h00, 8'h59);
        tick_wr(8'h01, 8'h30);
        rd("R5 coll sec", 8'h00, 8'h00);
        rd("R5 coll min", 8'h01, 8'h30);
        rd("R5 coll hour", 8'h02, 8'h00);
        wr(8'h00, 8'h20);
        tick_wr(8'h00, 8'h10);
        rd("R5 written sec wins", 8'h00, 8'h10);
        rd("R5 min kept", 8'h01, 8'h30);
        wr(8'h02, 8'h12);
        rd("R5 hour", 8'h02, 8'h12);
        rd("R5 sec untouched", 8'h00, 8'h10);
        rd("R5 min untouched", 8'h01, 8'h30);

        // R6 snapshot
        wr(8'h0D, 8'h41);
        tick1(); tick1();
        rd("R6 frozen sec", 8'h00, 8'h10);
        rd("R6 frozen hour", 8'h02, 8'h12);
        rd("R6 ctrl", 8'h0D, 8'h41);
        wr(8'h0D, 8'h01);
        rd("R6 live sec", 8'h00, 8'h12);

        // R8 R10 alarm
        wr(8'h0E, 8'hFC);
        set_time(8'h24, 8'h06, 8'h15, 8'h10, 8'h20, 8'h05);
        wr(8'h07, 8'h07); wr(8'h08, 8'h20); wr(8'h09, 8'h10);
        wr(8'h0A, 8'h15); wr(8'h0B, 8'h06); wr(8'h0C, 8'h24);
        wr(8'h0F, 8'h08);
        tick1();
        rd("R8 no match yet", 8'h0E, 8'h06);
        irq_is("R10 irq idle", 1'b0);
        tick1();
        rd("R8 match", 8'h0E, 8'h46);
        irq_is("R10 alarm irq", 1'b1);
        wr(8'h0E, 8'h00);
        rd("R9 alarm kept", 8'h0E, 8'h46);
        wr(8'h0E, 8'h40);
        rd("R9 alarm cleared", 8'h0E, 8'h06);
        irq_is("R10 irq dropped", 1'b0);

        // R10 periodic selection
        wr(8'h0F, 8'h05);
        wr(8'h0E, 8'hFC);
        wr(8'h00, 8'h58);
        tick1();
        rd("R7 sec only", 8'h0E, 8'h06);
        irq_is("R10 minute not yet", 1'b0);
        tick1();
        rd("R7 minute event", 8'h0E, 8'h0E);
        irq_is("R10 minute irq", 1'b1);
        wr(8'h0F, 8'h06);
        irq_is("R10 hour select", 1'b0);
        wr(8'h0F, 8'h04);
        irq_is("R10 second select", 1'b1);

        // R9 set beats clear in one cycle
        wr(8'h0F, 8'h00);
        wr(8'h0E, 8'hFC);
        rd("R9 cleared", 8'h0E, 8'h02);
        tick_wr(8'h0E, 8'h04);
        rd("R9 set wins", 8'h0E, 8'h06);

        finish_run();
    end

endmodule